// File: doc/BRIEF.md
# Display and Keypad Register Slave on a Two-Wire Bus

This block is the host-facing side of a display and keypad controller. It listens on a two-wire serial bus as a slave and recognises START, repeated START and STOP. It answers one 7-bit device address. The upper six address bits are fixed, and the lowest bit comes from a strap pin. Every byte it accepts is acknowledged. Both lines are oversampled by the system clock, passed through two-flop synchronizers and filtered, so short spikes never reach the protocol logic.

The first byte of a write loads a command pointer. Later bytes land in the register the pointer selects, and the pointer then steps forward. A read starts at the stored pointer and follows the same stepping rule. The pointer is kept across transactions, so a write of only the command byte sets up a later read. A repeated START between that write and the read keeps the pointer as well. The register file holds the display settings, the four digit registers and a discrete-segment register. It also returns two keypad status bytes that arrive on input ports.

Each accepted data byte appears on a registered write strobe together with its address and data. Each byte loaded for transmission raises a one-cycle read strobe together with its address, so the keypad logic can apply clear-on-read side effects. SDA is modelled as an open-drain output enable.

Top module: `dispkey_i2c_slave`

## Requirements
- R1: The slave acknowledges (holds SDA low through the ninth clock) only an address byte whose upper seven bits equal 0111000 with the last of them replaced by `addrStrap`. The lowest bit of the address byte is R/W: 0 means write and 1 means read. A non-matching address gets no acknowledge, and the slave stays silent until the next START.
- R2: The first byte after a write address is loaded into the command pointer. If STOP follows it directly, no register changes, and the pointer keeps the new value for later transactions.
- R3: Each further write byte is stored into the register at the pointer. The pointer then increments. One cycle later `wrStrobe` pulses for exactly one cycle with `wrAddr` set to the pointer and `wrData` set to the byte, and the target register updates in the cycle after that.
- R4: When the pointer equals 0x7F it does not increment, on either a write or a read.
- R5: A read returns bytes MSB first, starting at the stored pointer, and the pointer increments after each byte. The read continues while the master acknowledges. After a master NACK, and after any STOP, the slave releases SDA.
- R6: A repeated START after a pointer-setting write, followed by a read address, reads from that pointer.
- R7: When a byte is loaded for transmission, `rdStrobe` pulses for one cycle with `rdAddr` equal to that byte's register address. `rdStrobe` and `wrStrobe` are never high together.
- R8: Register map: 0x01 decode, 0x02 brightness, 0x03 scan limit, 0x04 configuration, 0x06 port configuration, 0x07 test (bit 0), 0x08 returns `keyDebIn`, 0x0C returns `keyLiveIn`, 0x20 to 0x23 digits 0 to 3, 0x24 segments. Writes to 0x08, 0x0C and unmapped addresses change nothing, and unmapped addresses read 0x00.
- R9: After reset: decode 0x00, brightness 0x04, scan limit 0x03, run bit 0, port configuration 0x80, test 0, all digits and segments 0x00.
- R10: Configuration bit 0 is the read-write run bit. Bit 1 is read-only and reads the `KEYPAD_FITTED` parameter. Writing bit 5 as 1 clears all digit and segment registers in the same update, and bit 5 always reads back as 0.
- R11: A pulse on either bus line that is shorter than `FILT_LEN` system clocks has no effect on the transfer.
- R12: `serDatOe` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| serClkIn | input | 1 | Bus clock line level |
| serDatIn | input | 1 | Bus data line level |
| serDatOe | output | 1 | Pulls the data line low when 1 |
| addrStrap | input | 1 | Lowest device address bit |
| keyDebIn | input | 8 | Debounced-key byte, returned at 0x08 |
| keyLiveIn | input | 8 | Live-key byte, returned at 0x0C |
| wrStrobe | output | 1 | One-cycle pulse per received write byte |
| wrAddr | output | 8 | Register address of the write |
| wrData | output | 8 | Written byte |
| rdStrobe | output | 1 | One-cycle pulse per byte loaded for transmission |
| rdAddr | output | 8 | Register address of the loaded byte |
| decodeMode | output | 8 | Decode register |
| brightness | output | 8 | Brightness register |
| scanLimit | output | 8 | Scan-limit register |
| runEnable | output | 1 | Configuration run bit |
| portCfg | output | 8 | Port configuration register |
| testMode | output | 1 | Display test bit |
| digitData | output | 32 | Digit registers, digit i at bits 8i+7:8i |
| segData | output | 8 | Discrete segment register |

## Verification
Writes are tried in several forms: a burst over the digit block, a command byte with nothing after it, a burst past 0x7F, writes to the read-only key addresses, and a configuration write with the clear bit set. Each form separates stepping, holding, ignoring and clearing of the pointer and the registers. Reads are tried after a STOP and after a repeated START, with a run of master ACKs ending in a NACK. This shows that the pointer is kept across transactions and that the data line is released on NACK. A wrong address under both strap values tells the address match apart from a fixed one. Spikes injected on both lines in the middle of a byte show that a corrupted shift or a false START is filtered out.

// File: rtl/dk_i2c_pkg.sv
package dk_i2c_pkg;

  localparam logic [5:0] DEV_ADDR_HI = 6'b011100;

  localparam logic [7:0] REG_DECODE     = 8'h01;
  localparam logic [7:0] REG_BRIGHT     = 8'h02;
  localparam logic [7:0] REG_SCANLIM    = 8'h03;
  localparam logic [7:0] REG_CONFIG     = 8'h04;
  localparam logic [7:0] REG_PORTCFG    = 8'h06;
  localparam logic [7:0] REG_TEST       = 8'h07;
  localparam logic [7:0] REG_KEYLATCH   = 8'h08;
  localparam logic [7:0] REG_KEYLIVE    = 8'h0C;
  localparam logic [7:0] REG_DIGIT_BASE = 8'h20;
  localparam logic [7:0] PTR_CEILING    = 8'h7F;

  localparam int CFG_RUN_BIT   = 0;
  localparam int CFG_TYPE_BIT  = 1;
  localparam int CFG_CLEAR_BIT = 5;

  localparam logic [7:0] BRIGHT_RST  = 8'h04;
  localparam logic [7:0] PORTCFG_RST = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadCmd;
    logic writeReg;
    logic loadRead;
    logic shiftOut;
  } dpStrobe_t;

endpackage

// File: rtl/dk_line_filter.sv
module dk_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic fltOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      fltOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == fltOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        fltOut <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dk_i2c_ctrl.sv
module dk_i2c_ctrl
  import dk_i2c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclFlt,
  input  logic      sdaFlt,
  input  logic      addrMatch,
  input  logic      rwBit,
  input  logic      txBit,
  output dpStrobe_t stb,
  output logic      serDatOe,
  output logic      busStop
);
  busState_t state;
  logic [3:0] bitCnt;
  logic sclPrev, sdaPrev;
  logic addrPhase, gotCmd, isRead, mAck;
  logic sclRise, sclFall, busStart;

  assign sclRise  = sclFlt & ~sclPrev;
  assign sclFall  = ~sclFlt & sclPrev;
  assign busStart = sclFlt & sclPrev & sdaPrev & ~sdaFlt;
  assign busStop  = sclFlt & sclPrev & ~sdaPrev & sdaFlt;

  assign serDatOe = (state == ST_ACK) || (state == ST_TX && !txBit);

  always_comb begin
    stb = '0;
    if (!busStart && !busStop) begin
      case (state)
        ST_RX: begin
          stb.shiftIn = sclRise;
          if (sclFall && bitCnt == 4'd8 && !addrPhase) begin
            stb.loadCmd  = ~gotCmd;
            stb.writeReg = gotCmd;
          end
        end
        ST_ACK:  stb.loadRead = sclFall & isRead;
        ST_TX:   stb.shiftOut = sclFall & (bitCnt != 4'd7);
        ST_MACK: stb.loadRead = sclFall & mAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      addrPhase <= 1'b0;
      gotCmd    <= 1'b0;
      isRead    <= 1'b0;
      mAck      <= 1'b0;
    end else begin
      sclPrev <= sclFlt;
      sdaPrev <= sdaFlt;
      if (busStart) begin
        state     <= ST_RX;
        bitCnt    <= '0;
        addrPhase <= 1'b1;
        gotCmd    <= 1'b0;
      end else if (busStop) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            if (sclFall && bitCnt == 4'd8) begin
              if (addrPhase) begin
                if (addrMatch) begin
                  isRead <= rwBit;
                  state  <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                gotCmd <= 1'b1;
                state  <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              addrPhase <= 1'b0;
              bitCnt    <= '0;
              state     <= isRead ? ST_TX : ST_RX;
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) state <= ST_MACK;
              else bitCnt <= bitCnt + 1'b1;
            end
          end
          ST_MACK: begin
            if (sclRise) mAck <= ~sdaFlt;
            if (sclFall) begin
              if (mAck) begin
                state  <= ST_TX;
                bitCnt <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dk_reg_datapath.sv
module dk_reg_datapath
  import dk_i2c_pkg::*;
#(
  parameter int NUM_DIGITS    = 4,
  parameter bit KEYPAD_FITTED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               stb,
  input  logic                    sdaBit,
  input  logic                    addrStrap,
  input  logic [7:0]              keyDebIn,
  input  logic [7:0]              keyLiveIn,
  output logic                    addrMatch,
  output logic                    rwBit,
  output logic                    txBit,
  output logic [7:0]              ptr,
  output logic                    wrStrobe,
  output logic [7:0]              wrAddr,
  output logic [7:0]              wrData,
  output logic                    rdStrobe,
  output logic [7:0]              rdAddr,
  output logic [7:0]              decodeMode,
  output logic [7:0]              brightness,
  output logic [7:0]              scanLimit,
  output logic                    runEnable,
  output logic [7:0]              portCfg,
  output logic                    testMode,
  output logic [NUM_DIGITS*8-1:0] digitData,
  output logic [7:0]              segData
);
  localparam logic [7:0] REG_SEGS     = 8'(REG_DIGIT_BASE + NUM_DIGITS);
  localparam logic [7:0] SCANLIM_RST  = 8'(NUM_DIGITS - 1);

  logic [7:0] shiftQ;
  logic [7:0] rdMux;
  logic [7:0] digitQ [NUM_DIGITS];
  logic       clearAll;
  logic       ptrStep;

  assign addrMatch = (shiftQ[7:1] == {DEV_ADDR_HI, addrStrap});
  assign rwBit     = shiftQ[0];
  assign txBit     = shiftQ[7];
  assign ptrStep   = (stb.writeReg | stb.loadRead) && (ptr != PTR_CEILING);
  assign clearAll  = wrStrobe && (wrAddr == REG_CONFIG) && wrData[CFG_CLEAR_BIT];

  always_comb begin
    rdMux = 8'h00;
    case (ptr)
      REG_DECODE:   rdMux = decodeMode;
      REG_BRIGHT:   rdMux = brightness;
      REG_SCANLIM:  rdMux = scanLimit;
      REG_CONFIG: begin
        rdMux[CFG_RUN_BIT]  = runEnable;
        rdMux[CFG_TYPE_BIT] = KEYPAD_FITTED;
      end
      REG_PORTCFG:  rdMux = portCfg;
      REG_TEST:     rdMux = {7'b0, testMode};
      REG_KEYLATCH: rdMux = keyDebIn;
      REG_KEYLIVE:  rdMux = keyLiveIn;
      REG_SEGS:     rdMux = segData;
      default:      ;
    endcase
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (ptr == 8'(REG_DIGIT_BASE + i)) rdMux = digitQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      ptr      <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      rdStrobe <= 1'b0;
      rdAddr   <= '0;
    end else begin
      if (stb.shiftIn)       shiftQ <= {shiftQ[6:0], sdaBit};
      else if (stb.loadRead) shiftQ <= rdMux;
      else if (stb.shiftOut) shiftQ <= {shiftQ[6:0], 1'b0};

      if (stb.loadCmd)  ptr <= shiftQ;
      else if (ptrStep) ptr <= ptr + 1'b1;

      wrStrobe <= stb.writeReg;
      rdStrobe <= stb.loadRead;
      if (stb.writeReg) begin
        wrAddr <= ptr;
        wrData <= shiftQ;
      end
      if (stb.loadRead) rdAddr <= ptr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decodeMode <= '0;
      brightness <= BRIGHT_RST;
      scanLimit  <= SCANLIM_RST;
      runEnable  <= 1'b0;
      portCfg    <= PORTCFG_RST;
      testMode   <= 1'b0;
      segData    <= '0;
    end else if (wrStrobe) begin
      case (wrAddr)
        REG_DECODE:  decodeMode <= wrData;
        REG_BRIGHT:  brightness <= wrData;
        REG_SCANLIM: scanLimit  <= wrData;
        REG_CONFIG:  runEnable  <= wrData[CFG_RUN_BIT];
        REG_PORTCFG: portCfg    <= wrData;
        REG_TEST:    testMode   <= wrData[0];
        default:     ;
      endcase
      if (clearAll) segData <= '0;
      else if (wrAddr == REG_SEGS) segData <= wrData;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    localparam logic [7:0] MY_ADDR = 8'(REG_DIGIT_BASE + g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) digitQ[g] <= '0;
      else if (clearAll) digitQ[g] <= '0;
      else if (wrStrobe && wrAddr == MY_ADDR) digitQ[g] <= wrData;
    end
    assign digitData[g*8 +: 8] = digitQ[g];
  end
endmodule

// File: rtl/dispkey_i2c_slave.sv
module dispkey_i2c_slave
  import dk_i2c_pkg::*;
#(
  parameter int FILT_LEN      = 4,
  parameter int NUM_DIGITS    = 4,
  parameter bit KEYPAD_FITTED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    serClkIn,
  input  logic                    serDatIn,
  output logic                    serDatOe,
  input  logic                    addrStrap,
  input  logic [7:0]              keyDebIn,
  input  logic [7:0]              keyLiveIn,
  output logic                    wrStrobe,
  output logic [7:0]              wrAddr,
  output logic [7:0]              wrData,
  output logic                    rdStrobe,
  output logic [7:0]              rdAddr,
  output logic [7:0]              decodeMode,
  output logic [7:0]              brightness,
  output logic [7:0]              scanLimit,
  output logic                    runEnable,
  output logic [7:0]              portCfg,
  output logic                    testMode,
  output logic [NUM_DIGITS*8-1:0] digitData,
  output logic [7:0]              segData
);
  logic [1:0] rawLines;
  logic [1:0] fltLines;
  logic       sclFlt, sdaFlt;
  logic       addrMatch, rwBit, txBit, busStop;
  logic [7:0] ptr;
  dpStrobe_t  stb;

  assign rawLines = {serDatIn, serClkIn};
  assign sclFlt   = fltLines[0];
  assign sdaFlt   = fltLines[1];

  for (genvar l = 0; l < 2; l++) begin : g_line
    dk_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[l]), .fltOut(fltLines[l])
    );
  end

  dk_i2c_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .sclFlt(sclFlt), .sdaFlt(sdaFlt),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit),
    .stb(stb), .serDatOe(serDatOe), .busStop(busStop)
  );

  dk_reg_datapath #(.NUM_DIGITS(NUM_DIGITS), .KEYPAD_FITTED(KEYPAD_FITTED)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaFlt), .addrStrap(addrStrap),
    .keyDebIn(keyDebIn), .keyLiveIn(keyLiveIn),
    .addrMatch(addrMatch), .rwBit(rwBit), .txBit(txBit), .ptr(ptr),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .decodeMode(decodeMode), .brightness(brightness), .scanLimit(scanLimit),
    .runEnable(runEnable), .portCfg(portCfg), .testMode(testMode),
    .digitData(digitData), .segData(segData)
  );
endmodule

// File: rtl/dispkey_i2c_slave_chk.sv
module dispkey_i2c_slave_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    busStop,
  input logic                    sclFlt,
  input logic                    serDatOe,
  input logic                    wrStrobe,
  input logic [7:0]              wrAddr,
  input logic [7:0]              wrData,
  input logic                    rdStrobe,
  input logic [7:0]              ptr,
  input logic [7:0]              brightness,
  input logic [NUM_DIGITS*8-1:0] digitData,
  input logic [7:0]              segData
);
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> !serDatOe); // R5

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serDatOe) |-> !sclFlt); // R12

  AST_BRIGHT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrAddr == 8'h02) |=> (brightness == $past(wrData))); // R3

  AST_CLEAR_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrAddr == 8'h04 && wrData[5]) |=> (digitData == '0 && segData == 8'h00)); // R10

  AST_PTR_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrAddr == 8'h7F) |-> (ptr == 8'h7F)); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe)); // R7
endmodule

bind dispkey_i2c_slave dispkey_i2c_slave_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk(clk), .rstN(rstN), .busStop(busStop), .sclFlt(sclFlt), .serDatOe(serDatOe),
  .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .rdStrobe(rdStrobe),
  .ptr(ptr), .brightness(brightness), .digitData(digitData), .segData(segData)
);

// File: tb/dispkey_i2c_slave_tb_top.sv
module dispkey_i2c_slave_tb_top;
  localparam int Q = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic addrStrap = 1'b0;
  logic [7:0] keyDeb = 8'hA5, keyLive = 8'h5A;
  logic serDatOe, wrStrobe, rdStrobe, runEnable, testMode;
  logic [7:0] wrAddr, wrData, rdAddr, decodeMode, brightness, scanLimit, portCfg, segData;
  logic [31:0] digitData;
  wire sdaLine = sdaM & ~serDatOe;

  dispkey_i2c_slave dut_i (
    .clk(clk), .rstN(rstN), .serClkIn(sclM), .serDatIn(sdaLine), .serDatOe(serDatOe),
    .addrStrap(addrStrap), .keyDebIn(keyDeb), .keyLiveIn(keyLive),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .decodeMode(decodeMode), .brightness(brightness), .scanLimit(scanLimit),
    .runEnable(runEnable), .portCfg(portCfg), .testMode(testMode),
    .digitData(digitData), .segData(segData)
  );

  int nChecks = 0, nErr = 0;
  bit settle = 1'b1, done = 1'b0;

  // behavioural model of the register state
  logic [7:0] mDec = 8'h00, mBri = 8'h04, mScan = 8'h03, mPort = 8'h80, mSeg = 8'h00;
  logic mRun = 1'b0, mTest = 1'b0;
  logic [7:0] mDig [4] = '{default: 8'h00};
  logic [7:0] mPtr = 8'h00;
  logic [7:0] rdQ[$], wrQ[$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mdlRead(input logic [7:0] a);
    case (a)
      8'h01: return mDec;
      8'h02: return mBri;
      8'h03: return mScan;
      8'h04: return {6'b0, 1'b1, mRun};
      8'h06: return mPort;
      8'h07: return {7'b0, mTest};
      8'h08: return keyDeb;
      8'h0C: return keyLive;
      8'h20, 8'h21, 8'h22, 8'h23: return mDig[a[1:0]];
      8'h24: return mSeg;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdlWrite(input logic [7:0] d);
    case (mPtr)
      8'h01: mDec = d;
      8'h02: mBri = d;
      8'h03: mScan = d;
      8'h04: begin
        mRun = d[0];
        if (d[5]) begin
          foreach (mDig[i]) mDig[i] = 8'h00;
          mSeg = 8'h00;
        end
      end
      8'h06: mPort = d;
      8'h07: mTest = d[0];
      8'h20, 8'h21, 8'h22, 8'h23: mDig[mPtr[1:0]] = d;
      8'h24: mSeg = d;
      default: ;
    endcase
    if (mPtr != 8'h7F) mPtr++;
  endtask

  function automatic logic [127:0] actVec();
    return {decodeMode, brightness, scanLimit, 7'b0, runEnable, portCfg, 7'b0, testMode, digitData, segData};
  endfunction
  function automatic logic [127:0] expVec();
    return {mDec, mBri, mScan, 7'b0, mRun, mPort, 7'b0, mTest, mDig[3], mDig[2], mDig[1], mDig[0], mSeg};
  endfunction

  // per-clock comparison against the model (R3, R8, R10 register outputs)
  always @(negedge clk) begin
    if (rstN && !settle && !done) chk(actVec() == expVec(), "R3/R8/R10 register outputs", actVec(), expVec());
  end

  // R12: data enable only moves while the bus clock is low
  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && serDatOe != prevOe) chk(!sclM, "R12 oe change with SCL high", sclM, 0);
    prevOe <= serDatOe;
  end

  always @(negedge clk) begin
    if (rdStrobe) rdQ.push_back(rdAddr);
    if (wrStrobe) wrQ.push_back(wrAddr);
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wq(Q); sclM = 1'b1; wq(Q); sdaM = 1'b0; wq(Q); sclM = 1'b0; wq(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq(Q); sclM = 1'b1; wq(Q); sdaM = 1'b1; wq(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    settle = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; wq(Q); sclM = 1'b1;
      if (glitch && i == 4) begin
        wq(Q); sdaM = 1'b0; wq(2); sdaM = b[i]; wq(Q - 2);
      end else wq(2*Q);
      sclM = 1'b0;
      if (glitch && i == 3) begin
        wq(Q/2); sclM = 1'b1; wq(2); sclM = 1'b0; wq(Q/2 - 2);
      end else wq(Q);
    end
    sdaM = 1'b1; wq(Q); sclM = 1'b1; wq(Q); ack = !sdaLine; wq(Q); sclM = 1'b0; wq(Q);
  endtask

  task automatic getByte(input bit mack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); sclM = 1'b1; wq(Q); b = {b[6:0], sdaLine}; wq(Q); sclM = 1'b0; wq(Q);
    end
    sdaM = mack ? 1'b0 : 1'b1; wq(Q); sclM = 1'b1; wq(2*Q); sclM = 1'b0; wq(Q); sdaM = 1'b1;
  endtask

  task automatic writeTxn(input logic [7:0] devByte, input logic [7:0] cmd, input logic [7:0] data[$], input bit glitch);
    bit ack;
    busStart();
    sendByte(devByte, 1'b0, ack); chk(ack, "R1 address ack", ack, 1);
    sendByte(cmd, 1'b0, ack); chk(ack, "R2 command ack", ack, 1);
    mPtr = cmd;
    foreach (data[k]) begin
      sendByte(data[k], glitch, ack); chk(ack, "R3 data ack", ack, 1);
      mdlWrite(data[k]);
    end
    settle = 1'b0;
    busStop();
  endtask

  task automatic readBody(input int n);
    bit ack;
    logic [7:0] b, e;
    sendByte(8'h71, 1'b0, ack); chk(ack, "R1 read address ack", ack, 1);
    settle = 1'b0;
    for (int k = 0; k < n; k++) begin
      e = mdlRead(mPtr);
      getByte(k != n - 1, b);
      chk(b == e, "R5/R8 read data", b, e);
      if (mPtr != 8'h7F) mPtr++;
    end
    chk(!serDatOe, "R5 released after NACK", serDatOe, 0);
    busStop();
  endtask

  task automatic readTxn(input int n);
    busStart();
    readBody(n);
  endtask

  initial begin
    bit ack;
    wq(5); rstN = 1'b1; wq(10);
    chk(actVec() == expVec(), "R9 reset values", actVec(), expVec());
    chk(!serDatOe && !wrStrobe && !rdStrobe, "R9 idle outputs", {serDatOe, wrStrobe, rdStrobe}, 0);

    // R1: wrong address with strap 0
    busStart(); sendByte(8'h72, 1'b0, ack); settle = 1'b0;
    chk(!ack, "R1 mismatch no ack", ack, 0); busStop();
    // R1: the same address accepted with strap 1
    addrStrap = 1'b1; wq(4);
    writeTxn(8'h72, 8'h01, '{8'h0F}, 1'b0);
    addrStrap = 1'b0; wq(4);
    busStart(); sendByte(8'h72, 1'b0, ack); settle = 1'b0;
    chk(!ack, "R1 strap back to 0 no ack", ack, 0); busStop();

    // R3: burst over digits and segments
    wrQ.delete();
    writeTxn(8'h70, 8'h20, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55}, 1'b0);
    chk(wrQ.size() == 5, "R3 strobe count", wrQ.size(), 5);
    foreach (wrQ[k]) chk(wrQ[k] == 8'(8'h20 + k), "R3 strobe address", wrQ[k], 8'h20 + k);

    // R2: command-only write, then a separate read
    writeTxn(8'h70, 8'h02, '{}, 1'b0);
    rdQ.delete();
    readTxn(1);
    chk(rdQ.size() == 1 && rdQ[0] == 8'h02, "R2/R7 read strobe address", rdQ.size() == 1 ? rdQ[0] : 8'hEE, 8'h02);

    // R6: repeated START keeps the pointer, burst read with ACKs then NACK
    rdQ.delete();
    busStart(); sendByte(8'h70, 1'b0, ack); sendByte(8'h20, 1'b0, ack);
    chk(ack, "R6 command ack", ack, 1);
    mPtr = 8'h20;
    busStart();
    readBody(5);
    chk(rdQ.size() == 5, "R7 read strobe count", rdQ.size(), 5);
    foreach (rdQ[k]) chk(rdQ[k] == 8'(8'h20 + k), "R7 read strobe address", rdQ[k], 8'h20 + k);

    // R8: read-only key registers ignore writes
    writeTxn(8'h70, 8'h08, '{8'h3C}, 1'b0);
    writeTxn(8'h70, 8'h08, '{}, 1'b0); readTxn(1);
    writeTxn(8'h70, 8'h0C, '{8'hC3}, 1'b0);
    writeTxn(8'h70, 8'h0C, '{}, 1'b0); readTxn(1);
    // R8: unmapped address reads zero
    writeTxn(8'h70, 8'h05, '{8'hFF}, 1'b0);
    writeTxn(8'h70, 8'h05, '{}, 1'b0); readTxn(1);

    // R10: run bit plus clear bit
    writeTxn(8'h70, 8'h04, '{8'h21}, 1'b0);
    chk(digitData == 32'h0 && segData == 8'h00, "R10 clear digits", {digitData, segData}, 0);
    chk(runEnable == 1'b1, "R10 run bit", runEnable, 1);
    writeTxn(8'h70, 8'h04, '{}, 1'b0); readTxn(1);

    // R4: pointer holds at 0x7F on write and read
    wrQ.delete();
    writeTxn(8'h70, 8'h7F, '{8'h01, 8'h02}, 1'b0);
    chk(wrQ.size() == 2 && wrQ[0] == 8'h7F && wrQ[1] == 8'h7F, "R4 write hold",
        wrQ.size() == 2 ? {wrQ[0], wrQ[1]} : 16'hEEEE, 16'h7F7F);
    rdQ.delete();
    readTxn(2);
    chk(rdQ.size() == 2 && rdQ[0] == 8'h7F && rdQ[1] == 8'h7F, "R4 read hold",
        rdQ.size() == 2 ? {rdQ[0], rdQ[1]} : 16'hEEEE, 16'h7F7F);

    // R11: spikes on both lines inside a data byte
    writeTxn(8'h70, 8'h03, '{8'h13}, 1'b1);
    chk(scanLimit == 8'h13, "R11 spikes rejected", scanLimit, 8'h13);
    writeTxn(8'h70, 8'h06, '{8'h41, 8'h01}, 1'b0);
    writeTxn(8'h70, 8'h06, '{}, 1'b0); readTxn(2);

    wq(20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nErr++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule